// File: doc/BRIEF.md
# Bus Phase Sequencer

This block stands between a simple memory-mapped master and a slow peripheral. It stretches each read or write into three phases whose lengths are set by parameters. In the setup phase the address and control go out with no strobe. In the access phase the read or write strobe is high for one cycle plus a number of extra wait cycles. In the hold phase the strobe is low again while the address and write data stay in place. Reads and writes each have their own set of three lengths. A phase with a length of zero is skipped and costs no cycle. The access phase is always present.

The master sees only `mst_waitreq`. It is high in every cycle of a transfer except the last one. When all three lengths are zero, a transfer finishes in the cycle it is presented. Read data is registered in the last access cycle and held until the transfer ends. If there is no hold phase, read data passes straight through in that access cycle. One transfer is in flight at a time. A new one is taken in the cycle after the previous one ends, so transfers can follow back to back.

The controller has four states. IDLE is left when a request appears. It goes to SETUP if the setup length is non-zero, otherwise straight to ACCESS. In IDLE, the first cycle of the request already counts as part of its first phase. SETUP moves to ACCESS after its count. ACCESS moves to HOLD after one cycle plus its wait count, or back to IDLE if the hold length is zero. HOLD returns to IDLE after its count.

Top module: `bus_phase_seq`

## Requirements
- R1: After reset, and whenever no request is present, `mst_waitreq`, `slv_cs`, `slv_rd` and `slv_wr` are all low.
- R2: A transfer runs setup, then access, then hold, in that order. Setup lasts exactly the setup length of the direction, and hold lasts exactly the hold length. A zero length adds no cycle.
- R3: With zero setup, wait and hold lengths, a read finishes in the cycle it is presented: `mst_waitreq` is low in that cycle and `mst_rdata` carries the slave's data.
- R4: A read takes RD_SETUP + RD_WAIT + 1 + RD_HOLD cycles. `mst_waitreq` is high in every one of those cycles except the last.
- R5: A write takes WR_SETUP + WR_WAIT + 1 + WR_HOLD cycles. With all three lengths zero, this is a single cycle.
- R6: The strobe of the transfer's direction is high for exactly 1 + wait-length cycles, all inside the access phase. `slv_cs` is high in every cycle of the transfer.
- R7: Read data is captured in the last access cycle. It is returned in the cycle `mst_waitreq` falls, even if the slave's data changes during hold.
- R8: Read and write timing come from separate parameters. A request with both `mst_read` and `mst_write` high is handled as a write, with write timing and `slv_wr`. Only the strobe of the transfer's own direction is ever raised.
- R9: A new request is accepted in the cycle right after the previous transfer ends, so back-to-back transfers each keep their full timing.
- R10: `slv_addr` and `slv_wdata` follow the master's address and write data unchanged for the whole transfer. The master keeps its address, data and control stable while `mst_waitreq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all phases |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_addr | input | AW | Master address |
| mst_read | input | 1 | Master read request |
| mst_write | input | 1 | Master write request (wins over read) |
| mst_wdata | input | DW | Master write data |
| mst_rdata | output | DW | Read data returned to the master |
| mst_waitreq | output | 1 | Stall: high until the transfer's last cycle |
| slv_cs | output | 1 | Peripheral select, high for the whole transfer |
| slv_rd | output | 1 | Peripheral read strobe (access phase only) |
| slv_wr | output | 1 | Peripheral write strobe (access phase only) |
| slv_addr | output | AW | Address to the peripheral |
| slv_wdata | output | DW | Write data to the peripheral |
| slv_rdata | input | DW | Read data from the peripheral |

## Verification
Every result is due a fixed number of cycles after a request: setup length + wait length + 1 + hold length. The setup and access cycles come first, and the hold cycles end the transfer. The driver computes these counts from the bench's own copies of the parameters and queues them. The monitor samples at the falling edge and sorts each request cycle by the strobes: before the first strobe, during the strobes, or after them. When `mst_waitreq` drops, the monitor compares the totals and the returned data with the queued entry. The slave model returns different data once the strobe falls, so a read value taken at the wrong cycle shows up as a mismatch.

// File: rtl/bps_pkg.sv
package bps_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2,
        PH_HOLD   = 2'd3
    } bps_phase_e;
endpackage

// File: rtl/bps_phase_ctrl.sv
module bps_phase_ctrl
    import bps_pkg::*;
#(
    parameter int RD_SETUP = 1,
    parameter int RD_WAIT  = 1,
    parameter int RD_HOLD  = 1,
    parameter int WR_SETUP = 1,
    parameter int WR_WAIT  = 0,
    parameter int WR_HOLD  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       wr_req,
    output bps_phase_e phase,
    output logic       dir,
    output logic       last_access,
    output logic       done
);
    localparam int MAX_RD  = (RD_SETUP > RD_WAIT) ? ((RD_SETUP > RD_HOLD) ? RD_SETUP : RD_HOLD)
                                                  : ((RD_WAIT > RD_HOLD) ? RD_WAIT : RD_HOLD);
    localparam int MAX_WR  = (WR_SETUP > WR_WAIT) ? ((WR_SETUP > WR_HOLD) ? WR_SETUP : WR_HOLD)
                                                  : ((WR_WAIT > WR_HOLD) ? WR_WAIT : WR_HOLD);
    localparam int MAX_LEN = (MAX_RD > MAX_WR) ? MAX_RD : MAX_WR;
    localparam int CW      = $clog2(MAX_LEN + 2);

    bps_phase_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d, cnt_cur;
    logic          dir_q;
    int            s_len, w_len, h_len;
    logic          last_setup, last_hold;

    // Direction is sampled in the first cycle and held for the transfer.
    always_comb begin
        dir   = (state_q == PH_IDLE) ? wr_req : dir_q;
        s_len = dir ? WR_SETUP : RD_SETUP;
        w_len = dir ? WR_WAIT  : RD_WAIT;
        h_len = dir ? WR_HOLD  : RD_HOLD;
    end

    // The request cycle in IDLE already counts as the first phase cycle.
    always_comb begin
        phase   = state_q;
        cnt_cur = cnt_q;
        if (state_q == PH_IDLE) begin
            cnt_cur = '0;
            if (req) phase = (s_len > 0) ? PH_SETUP : PH_ACCESS;
        end
    end

    always_comb begin
        last_setup  = (phase == PH_SETUP)  && (int'(cnt_cur) == s_len - 1);
        last_access = (phase == PH_ACCESS) && (int'(cnt_cur) == w_len);
        last_hold   = (phase == PH_HOLD)   && (int'(cnt_cur) == h_len - 1);
        done        = (last_access && (h_len == 0)) || last_hold;
    end

    // Next-state decision
    always_comb begin
        state_d = phase;
        cnt_d   = cnt_cur + 1'b1;
        unique case (phase)
            PH_IDLE: begin
                state_d = PH_IDLE;
                cnt_d   = '0;
            end
            PH_SETUP: begin
                if (last_setup) begin
                    state_d = PH_ACCESS;
                    cnt_d   = '0;
                end
            end
            PH_ACCESS: begin
                if (last_access) begin
                    state_d = (h_len == 0) ? PH_IDLE : PH_HOLD;
                    cnt_d   = '0;
                end
            end
            PH_HOLD: begin
                if (last_hold) begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            dir_q   <= dir;
        end
    end

    AST_SETUP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SETUP) |=> (state_q == PH_SETUP || state_q == PH_ACCESS)); // R2
    AST_HOLD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HOLD) |=> (state_q == PH_HOLD || state_q == PH_IDLE)); // R2
    AST_ACCESS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ACCESS) |-> (int'(cnt_q) <= w_len)); // R6
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == PH_IDLE)); // R9
endmodule

// File: rtl/bps_rdata_hold.sv
module bps_rdata_hold
    import bps_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bps_phase_e    phase,
    input  logic          capture,
    input  logic          rd_dir,
    input  logic [DW-1:0] slv_rdata,
    output logic [DW-1:0] mst_rdata
);
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (capture && rd_dir)  rdata_q <= slv_rdata;
    end

    // Pass through on the final access cycle so a zero-hold read needs no extra cycle.
    always_comb mst_rdata = capture ? slv_rdata : rdata_q;

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && $past(phase == PH_HOLD)) |-> $stable(rdata_q)); // R7
endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
    import bps_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int RD_SETUP = 1,
    parameter int RD_WAIT  = 1,
    parameter int RD_HOLD  = 1,
    parameter int WR_SETUP = 1,
    parameter int WR_WAIT  = 0,
    parameter int WR_HOLD  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] mst_addr,
    input  logic          mst_read,
    input  logic          mst_write,
    input  logic [DW-1:0] mst_wdata,
    output logic [DW-1:0] mst_rdata,
    output logic          mst_waitreq,
    output logic          slv_cs,
    output logic          slv_rd,
    output logic          slv_wr,
    output logic [AW-1:0] slv_addr,
    output logic [DW-1:0] slv_wdata,
    input  logic [DW-1:0] slv_rdata
);
    bps_phase_e phase;
    logic       dir, last_access, done;

    bps_phase_ctrl #(
        .RD_SETUP(RD_SETUP), .RD_WAIT(RD_WAIT), .RD_HOLD(RD_HOLD),
        .WR_SETUP(WR_SETUP), .WR_WAIT(WR_WAIT), .WR_HOLD(WR_HOLD)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (mst_read | mst_write),
        .wr_req     (mst_write),
        .phase      (phase),
        .dir        (dir),
        .last_access(last_access),
        .done       (done)
    );

    bps_rdata_hold #(.DW(DW)) u_rdata (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .capture  (last_access),
        .rd_dir   (!dir),
        .slv_rdata(slv_rdata),
        .mst_rdata(mst_rdata)
    );

    // Output decode
    always_comb begin
        mst_waitreq = (phase != PH_IDLE) && !done;
        slv_cs      = (phase != PH_IDLE);
        slv_rd      = (phase == PH_ACCESS) && !dir;
        slv_wr      = (phase == PH_ACCESS) && dir;
        slv_addr    = mst_addr;
        slv_wdata   = mst_wdata;
    end

    AST_MASTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mst_waitreq |=> ($stable(mst_addr) && $stable(mst_read) && $stable(mst_write))); // R10
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_rd || slv_wr) |-> slv_cs); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(mst_read || mst_write) && !slv_cs |-> !mst_waitreq); // R1
endmodule

// File: tb/bus_phase_seq_bench.sv
module bus_phase_seq_bench;
    localparam int RS0 = 1, RW0 = 1, RH0 = 1, WS0 = 1, WW0 = 0, WH0 = 1;

    typedef struct {
        string       tag;
        int          cycles;
        int          setup;
        int          strobes;
        int          hold;
        bit          chk_rd;
        logic [31:0] rd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] m_addr  [2];
    logic        m_rd    [2];
    logic        m_wr    [2];
    logic [31:0] m_wdata [2];
    logic [31:0] m_rdata [2];
    logic        wq      [2];
    logic        s_cs    [2];
    logic        s_rd    [2];
    logic        s_wr    [2];
    logic [15:0] s_addr  [2];
    logic [31:0] s_wdata [2];
    logic [31:0] s_rdata [2];

    int checks = 0, fails = 0, wd = 0;
    exp_t q0[$], q1[$];
    int cyc[2], stb[2], pre[2], post[2];
    bit cs_bad[2], dir_bad[2], pass_bad[2];

    always #5 clk = ~clk;

    function automatic logic [31:0] slave_fn(logic [15:0] a);
        return {a, ~a} ^ 32'hA5C3_0F96;
    endfunction

    assign s_rdata[0] = s_rd[0] ? slave_fn(s_addr[0]) : {16'hDEAD, s_addr[0]};
    assign s_rdata[1] = s_rd[1] ? slave_fn(s_addr[1]) : {16'hDEAD, s_addr[1]};

    bus_phase_seq #(.RD_SETUP(RS0), .RD_WAIT(RW0), .RD_HOLD(RH0),
                    .WR_SETUP(WS0), .WR_WAIT(WW0), .WR_HOLD(WH0)) u_bus_phase_seq (
        .clk(clk), .rst_n(rst_n), .mst_addr(m_addr[0]), .mst_read(m_rd[0]),
        .mst_write(m_wr[0]), .mst_wdata(m_wdata[0]), .mst_rdata(m_rdata[0]),
        .mst_waitreq(wq[0]), .slv_cs(s_cs[0]), .slv_rd(s_rd[0]), .slv_wr(s_wr[0]),
        .slv_addr(s_addr[0]), .slv_wdata(s_wdata[0]), .slv_rdata(s_rdata[0]));

    bus_phase_seq #(.RD_SETUP(0), .RD_WAIT(0), .RD_HOLD(0),
                    .WR_SETUP(0), .WR_WAIT(0), .WR_HOLD(0)) u_bus_phase_seq_zero (
        .clk(clk), .rst_n(rst_n), .mst_addr(m_addr[1]), .mst_read(m_rd[1]),
        .mst_write(m_wr[1]), .mst_wdata(m_wdata[1]), .mst_rdata(m_rdata[1]),
        .mst_waitreq(wq[1]), .slv_cs(s_cs[1]), .slv_rd(s_rd[1]), .slv_wr(s_wr[1]),
        .slv_addr(s_addr[1]), .slv_wdata(s_wdata[1]), .slv_rdata(s_rdata[1]));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Driver: queue the expected timing, then present and hold the request.
    task automatic xfer(int i, bit rd, bit wr, logic [15:0] a, logic [31:0] d, string tag);
        exp_t e;
        int s, w, h;
        if (i == 0) begin
            s = wr ? WS0 : RS0; w = wr ? WW0 : RW0; h = wr ? WH0 : RH0;
        end else begin
            s = 0; w = 0; h = 0;
        end
        e.tag = tag; e.setup = s; e.strobes = 1 + w; e.hold = h;
        e.cycles = s + w + 1 + h; e.chk_rd = !wr; e.rd = slave_fn(a);
        if (i == 0) q0.push_back(e); else q1.push_back(e);
        m_addr[i] = a; m_wdata[i] = d; m_rd[i] = rd; m_wr[i] = wr;
        do @(negedge clk); while (wq[i]);
        @(posedge clk); #1;
        m_rd[i] = 1'b0; m_wr[i] = 1'b0;
    endtask

    task automatic idle_check(int n, string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk({req, " idle waitreq"}, {31'd0, wq[0] | wq[1]}, 32'd0);
            chk({req, " idle select/strobes"},
                {31'd0, s_cs[0] | s_cs[1] | s_rd[0] | s_wr[0] | s_rd[1] | s_wr[1]}, 32'd0);
        end
        @(posedge clk); #1;
    endtask

    // Monitor: classify every request cycle, compare on completion.
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (rst_n && (m_rd[i] || m_wr[i])) begin
                exp_t e;
                cyc[i]++;
                if (!s_cs[i]) cs_bad[i] = 1'b1;
                if (s_addr[i] !== m_addr[i] || s_wdata[i] !== m_wdata[i]) pass_bad[i] = 1'b1;
                if (s_rd[i] || s_wr[i]) begin
                    stb[i]++;
                    if (m_wr[i] ? s_rd[i] : s_wr[i]) dir_bad[i] = 1'b1;
                    if (post[i] != 0) dir_bad[i] = 1'b1;
                end else if (stb[i] == 0) pre[i]++;
                else post[i]++;
                if (!wq[i]) begin
                    if ((i == 0 && q0.size() == 0) || (i == 1 && q1.size() == 0)) begin
                        chk("R9 unexpected completion", 32'd1, 32'd0);
                    end else begin
                        e = (i == 0) ? q0.pop_front() : q1.pop_front();
                        chk({e.tag, " total cycles"}, cyc[i], e.cycles);
                        chk("R2 setup cycles", pre[i], e.setup);
                        chk("R6 strobe cycles", stb[i], e.strobes);
                        chk("R2 hold cycles", post[i], e.hold);
                        chk("R6 chip select held", {31'd0, cs_bad[i]}, 32'd0);
                        chk("R8 strobe direction", {31'd0, dir_bad[i]}, 32'd0);
                        chk("R10 address/data passthrough", {31'd0, pass_bad[i]}, 32'd0);
                        if (e.chk_rd) chk("R7 read data", m_rdata[i], e.rd);
                    end
                    cyc[i] = 0; stb[i] = 0; pre[i] = 0; post[i] = 0;
                    cs_bad[i] = 1'b0; dir_bad[i] = 1'b0; pass_bad[i] = 1'b0;
                end
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd == 50000) begin
            fails++;
            $display("FAIL R9 watchdog: actual %0d cycles expected completion", wd);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_addr[i] = '0; m_rd[i] = 1'b0; m_wr[i] = 1'b0; m_wdata[i] = '0;
            cyc[i] = 0; stb[i] = 0; pre[i] = 0; post[i] = 0;
            cs_bad[i] = 1'b0; dir_bad[i] = 1'b0; pass_bad[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1 waitreq in reset", {31'd0, wq[0] | wq[1]}, 32'd0);
        chk("R1 select in reset", {31'd0, s_cs[0] | s_cs[1]}, 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle_check(2, "R1");

        // Stretched instance
        xfer(0, 1'b1, 1'b0, 16'h0010, 32'h0, "R4 read");
        idle_check(1, "R1");
        xfer(0, 1'b0, 1'b1, 16'h0020, 32'hCAFE_0001, "R5 write");
        idle_check(1, "R1");
        xfer(0, 1'b1, 1'b0, 16'h0031, 32'h0, "R9 back-to-back read");
        xfer(0, 1'b0, 1'b1, 16'h0042, 32'h1234_5678, "R9 back-to-back write");
        xfer(0, 1'b1, 1'b0, 16'h0053, 32'h0, "R9 back-to-back read");
        xfer(0, 1'b1, 1'b1, 16'h0064, 32'h8765_4321, "R8 read+write as write");
        idle_check(2, "R1");

        // Zero-length instance
        xfer(1, 1'b1, 1'b0, 16'h0A01, 32'h0, "R3 zero-cycle read");
        xfer(1, 1'b0, 1'b1, 16'h0A02, 32'h5555_AAAA, "R5 single-cycle write");
        xfer(1, 1'b1, 1'b0, 16'h0A03, 32'h0, "R3 back-to-back read");
        xfer(1, 1'b1, 1'b0, 16'hFFFF, 32'h0, "R3 back-to-back read");
        idle_check(2, "R1");

        chk("R9 all transfers completed", q0.size() + q1.size(), 32'd0);
        summary();
        $finish;
    end
endmodule